// File: doc/BRIEF.md
# Control-Symbol Receive Decoder

This block takes one decoded link symbol per clock, a byte with a flag that marks it as a control (K) symbol, from an upstream 8b/10b decoder and word-alignment stage. It sorts every control symbol into one of several classes: idle filler, global reset, frame start, frame end, or one of eight trigger classes. Any K byte outside that set is treated as unknown. Each trigger class fires a one-clock strobe on its own bit of an 8-bit trigger bus. Global reset fires a one-clock reset pulse.

Frames are bounded by a start symbol and an end symbol. The plain bytes between them go to a message layer on a byte stream that carries start, valid and end markers. Triggers, idle and global reset may be interleaved inside a frame. They take effect with the same one-register latency as anywhere else. They never appear as payload and never break the frame. Protocol violations set a sticky error flag that only reset or a global-reset symbol clears.

Top module: `kc_rx_decoder`

## Requirements
- R1: With sym_is_k=1, the bytes 0x5C, 0x7C, 0x9C, 0xDC, 0xFC, 0xF7, 0xFB and 0xFD set trig_o bit 0, 1, 2, 3, 4, 5, 6 and 7 respectively. The bit is set in the clock after the symbol is presented, whatever the frame state.
- R2: Each trigger strobe lasts one clock per trigger symbol, and at most one trig_o bit is high in any cycle.
- R3: The idle symbol (K, 0xBC) changes nothing: it produces no strobe, no payload marker and no error, and it leaves the frame state unchanged.
- R4: The global-reset symbol (K, 0x3C) raises gr_pulse_o for exactly the next clock. It also closes any open frame and clears proto_err_o.
- R5: The frame-start symbol (K, 0x1C) raises pl_sof_o in the next clock and opens a frame.
- R6: A non-control symbol inside an open frame appears on pl_data_o with pl_valid_o high in the next clock, in arrival order and with no gaps added.
- R7: A control symbol inside an open frame that is neither frame start nor frame end never raises pl_valid_o and does not close the frame.
- R8: The frame-end symbol (K, 0xFE) inside an open frame raises pl_eof_o in the next clock and closes the frame.
- R9: proto_err_o rises in the next clock and stays high after any of these: a data byte outside a frame, a frame end outside a frame, a frame start inside a frame, or a K byte outside the twelve listed codes. A frame start inside a frame still raises pl_sof_o and restarts the frame.
- R10: While rst_n is low and in the first cycle after it is released, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_data | input | 8 | Decoded symbol byte |
| sym_is_k | input | 1 | High when sym_data is a control symbol |
| trig_o | output | 8 | One-clock trigger strobes, one bit per trigger class |
| gr_pulse_o | output | 1 | One-clock global-reset pulse |
| pl_sof_o | output | 1 | Frame-start marker to the message layer |
| pl_valid_o | output | 1 | Payload byte valid |
| pl_data_o | output | 8 | Payload byte |
| pl_eof_o | output | 1 | Frame-end marker to the message layer |
| proto_err_o | output | 1 | Sticky protocol-violation flag |

## Verification
The only hidden state is the open-frame flag. If it is wrong, the ports show it in the cycle after the next data or framing symbol: a payload byte is dropped while proto_err_o rises, a stray pl_valid_o appears, or an end marker goes missing. The bench keeps its own frame and error model and compares every output on every cycle. A corrupted frame flag is therefore caught one clock after the first symbol whose handling depends on it. Trigger mapping and latency faults are visible in the very next cycle, because each of the eight codes is sent both inside and outside a frame.

// File: rtl/kc_rx_pkg.sv
package kc_rx_pkg;

    localparam int SYM_W  = 8;
    localparam int TRIG_N = 8;

    localparam logic [SYM_W-1:0] K_FILL  = 8'hBC;
    localparam logic [SYM_W-1:0] K_GRST  = 8'h3C;
    localparam logic [SYM_W-1:0] K_START = 8'h1C;
    localparam logic [SYM_W-1:0] K_END   = 8'hFE;

    typedef enum logic [2:0] {
        SC_DATA,
        SC_FILL,
        SC_GRST,
        SC_START,
        SC_END,
        SC_TRIG,
        SC_BAD
    } sym_class_e;

    // byte value that selects trigger bus bit idx
    function automatic logic [SYM_W-1:0] trig_code(input int idx);
        case (idx)
            0:       return 8'h5C;
            1:       return 8'h7C;
            2:       return 8'h9C;
            3:       return 8'hDC;
            4:       return 8'hFC;
            5:       return 8'hF7;
            6:       return 8'hFB;
            default: return 8'hFD;
        endcase
    endfunction

    typedef struct packed {
        logic              in_frame;
        logic              err;
        logic [TRIG_N-1:0] trig;
        logic              grst;
        logic              sof;
        logic              valid;
        logic [SYM_W-1:0]  data;
        logic              eof;
    } rx_state_t;

endpackage

// File: rtl/kc_classify.sv
module kc_classify
    import kc_rx_pkg::*;
#(
    parameter int W  = SYM_W,
    parameter int NT = TRIG_N
) (
    input  logic [W-1:0]  sym_data,
    input  logic          sym_is_k,
    output sym_class_e    cls,
    output logic [NT-1:0] trig_hit
);

    for (genvar g = 0; g < NT; g++) begin : g_trig_cmp
        assign trig_hit[g] = sym_is_k && (sym_data == trig_code(g));
    end

    always_comb begin
        if (!sym_is_k) begin
            cls = SC_DATA;
        end else if (|trig_hit) begin
            cls = SC_TRIG;
        end else begin
            case (sym_data)
                K_FILL:  cls = SC_FILL;
                K_GRST:  cls = SC_GRST;
                K_START: cls = SC_START;
                K_END:   cls = SC_END;
                default: cls = SC_BAD;
            endcase
        end
    end

endmodule

// File: rtl/kc_frame_ctl.sv
module kc_frame_ctl
    import kc_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  sym_class_e          cls,
    input  logic [TRIG_N-1:0]   trig_hit,
    input  logic [SYM_W-1:0]    sym_data,
    output rx_state_t           st_q
);

    rx_state_t st_d;

    always_comb begin
        st_d       = st_q;
        st_d.trig  = '0;
        st_d.grst  = 1'b0;
        st_d.sof   = 1'b0;
        st_d.valid = 1'b0;
        st_d.eof   = 1'b0;
        case (cls)
            SC_DATA: begin
                if (st_q.in_frame) begin
                    st_d.valid = 1'b1;
                    st_d.data  = sym_data;
                end else begin
                    st_d.err = 1'b1;
                end
            end
            SC_START: begin
                st_d.sof      = 1'b1;
                st_d.in_frame = 1'b1;
                if (st_q.in_frame) st_d.err = 1'b1;
            end
            SC_END: begin
                if (st_q.in_frame) begin
                    st_d.eof      = 1'b1;
                    st_d.in_frame = 1'b0;
                end else begin
                    st_d.err = 1'b1;
                end
            end
            SC_GRST: begin
                st_d.grst     = 1'b1;
                st_d.in_frame = 1'b0;
                st_d.err      = 1'b0;
            end
            SC_TRIG: st_d.trig = trig_hit;
            SC_BAD:  st_d.err  = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/kc_rx_decoder.sv
module kc_rx_decoder
    import kc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYM_W-1:0]  sym_data,
    input  logic              sym_is_k,
    output logic [TRIG_N-1:0] trig_o,
    output logic              gr_pulse_o,
    output logic              pl_sof_o,
    output logic              pl_valid_o,
    output logic [SYM_W-1:0]  pl_data_o,
    output logic              pl_eof_o,
    output logic              proto_err_o
);

    sym_class_e        cls;
    logic [TRIG_N-1:0] trig_hit;
    rx_state_t         st_q;

    kc_classify #(.W(SYM_W), .NT(TRIG_N)) classify_i (
        .sym_data (sym_data),
        .sym_is_k (sym_is_k),
        .cls      (cls),
        .trig_hit (trig_hit)
    );

    kc_frame_ctl frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls      (cls),
        .trig_hit (trig_hit),
        .sym_data (sym_data),
        .st_q     (st_q)
    );

    assign trig_o      = st_q.trig;
    assign gr_pulse_o  = st_q.grst;
    assign pl_sof_o    = st_q.sof;
    assign pl_valid_o  = st_q.valid;
    assign pl_data_o   = st_q.data;
    assign pl_eof_o    = st_q.eof;
    assign proto_err_o = st_q.err;

endmodule

// File: rtl/kc_rx_checker.sv
module kc_rx_checker
    import kc_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SYM_W-1:0]  sym_data,
    input logic              sym_is_k,
    input logic [TRIG_N-1:0] trig_o,
    input logic              gr_pulse_o,
    input logic              pl_sof_o,
    input logic              pl_valid_o,
    input logic              pl_eof_o,
    input logic              proto_err_o
);

    p_trig_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_is_k && sym_data == 8'h5C) |=> trig_o[0]);

    p_trig_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_is_k && sym_data == 8'hFD) |=> trig_o[7]);

    p_trig_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trig_o));

    p_trig_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_is_k) |=> (trig_o == '0));

    p_grst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_is_k && sym_data == 8'h3C) |=> (gr_pulse_o && !proto_err_o));

    p_ctrl_no_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sym_is_k |=> !pl_valid_o);

    p_start_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_is_k && sym_data == 8'h1C) |=> pl_sof_o);

    p_markers_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pl_sof_o, pl_valid_o, pl_eof_o, gr_pulse_o}));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err_o && !(sym_is_k && sym_data == 8'h3C)) |=> proto_err_o);

endmodule

bind kc_rx_decoder kc_rx_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_data    (sym_data),
    .sym_is_k    (sym_is_k),
    .trig_o      (trig_o),
    .gr_pulse_o  (gr_pulse_o),
    .pl_sof_o    (pl_sof_o),
    .pl_valid_o  (pl_valid_o),
    .pl_eof_o    (pl_eof_o),
    .proto_err_o (proto_err_o)
);

// File: tb/kc_rx_decoder_tb_top.sv
module kc_rx_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sym_data = 8'hBC;
    logic       sym_is_k = 1'b1;
    logic [7:0] trig_o;
    logic       gr_pulse_o, pl_sof_o, pl_valid_o, pl_eof_o, proto_err_o;
    logic [7:0] pl_data_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    bit         m_frame = 1'b0;
    bit         m_err = 1'b0;
    logic [7:0] e_trig = '0;
    bit         e_gr = 1'b0, e_sof = 1'b0, e_val = 1'b0, e_eof = 1'b0;
    logic [7:0] e_data = '0;

    always #10 clk = ~clk;

    kc_rx_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .sym_data(sym_data), .sym_is_k(sym_is_k),
        .trig_o(trig_o), .gr_pulse_o(gr_pulse_o), .pl_sof_o(pl_sof_o),
        .pl_valid_o(pl_valid_o), .pl_data_o(pl_data_o), .pl_eof_o(pl_eof_o),
        .proto_err_o(proto_err_o)
    );

    function automatic logic [7:0] tcode(input int i);
        case (i)
            0: return 8'h5C; 1: return 8'h7C; 2: return 8'h9C; 3: return 8'hDC;
            4: return 8'hFC; 5: return 8'hF7; 6: return 8'hFB; default: return 8'hFD;
        endcase
    endfunction

    function automatic int trig_index(input logic [7:0] d);
        for (int i = 0; i < 8; i++) if (tcode(i) == d) return i;
        return -1;
    endfunction

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        cmp("R1/R2", "trig_o", {24'd0, trig_o}, {24'd0, e_trig});
        cmp("R4", "gr_pulse_o", {31'd0, gr_pulse_o}, {31'd0, e_gr});
        cmp("R5", "pl_sof_o", {31'd0, pl_sof_o}, {31'd0, e_sof});
        cmp("R6/R7", "pl_valid_o", {31'd0, pl_valid_o}, {31'd0, e_val});
        if (e_val) cmp("R6", "pl_data_o", {24'd0, pl_data_o}, {24'd0, e_data});
        cmp("R8", "pl_eof_o", {31'd0, pl_eof_o}, {31'd0, e_eof});
        cmp("R9", "proto_err_o", {31'd0, proto_err_o}, {31'd0, m_err});
    endtask

    // model of the next-cycle outputs from the requirements
    task automatic model(input bit k, input logic [7:0] d);
        int ti;
        e_trig = '0; e_gr = 0; e_sof = 0; e_val = 0; e_eof = 0;
        ti = trig_index(d);
        if (!k) begin
            if (m_frame) begin e_val = 1; e_data = d; end   // R6
            else m_err = 1;                                  // R9
        end else if (ti >= 0) begin
            e_trig[ti] = 1'b1;                               // R1
        end else if (d == 8'hBC) begin
            // R3: no effect
        end else if (d == 8'h3C) begin
            e_gr = 1; m_frame = 0; m_err = 0;                // R4
        end else if (d == 8'h1C) begin
            e_sof = 1; if (m_frame) m_err = 1; m_frame = 1;  // R5, R9
        end else if (d == 8'hFE) begin
            if (m_frame) begin e_eof = 1; m_frame = 0; end   // R8
            else m_err = 1;
        end else begin
            m_err = 1;                                       // R9 unknown K
        end
    endtask

    task automatic send(input bit k, input logic [7:0] d);
        @(negedge clk);
        check_outputs();
        sym_is_k = k;
        sym_data = d;
        model(k, d);
    endtask

    task automatic send_rand();
        int r;
        logic [7:0] bad [4] = '{8'h00, 8'h55, 8'hAA, 8'hFF};
        r = int'($urandom % 100);
        if (r < 40)      send(1'b0, 8'($urandom));
        else if (r < 56) send(1'b1, tcode(int'($urandom % 8)));
        else if (r < 66) send(1'b1, 8'h1C);
        else if (r < 78) send(1'b1, 8'hFE);
        else if (r < 88) send(1'b1, 8'hBC);
        else if (r < 92) send(1'b1, 8'h3C);
        else if (r < 95) send(1'b1, bad[$urandom % 4]);
        else             send(1'b0, 8'($urandom));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4060));
        repeat (3) @(negedge clk);
        // R10: reset state during reset
        cmp("R10", "trig_o in reset", {24'd0, trig_o}, 32'd0);
        cmp("R10", "markers in reset", {27'd0, gr_pulse_o, pl_sof_o, pl_valid_o, pl_eof_o, proto_err_o}, 32'd0);
        rst_n = 1'b1;
        // first send checks the first post-reset cycle (R10)

        // R1: each trigger outside a frame
        for (int i = 0; i < 8; i++) send(1'b1, tcode(i));
        // R2: back-to-back identical triggers, then idle gap (R3)
        send(1'b1, 8'h5C); send(1'b1, 8'h5C); send(1'b1, 8'hBC);
        // R5/R6/R7/R8: frame with every trigger, idle interleaved in the payload
        send(1'b1, 8'h1C);
        for (int i = 0; i < 8; i++) begin
            send(1'b0, 8'(8'h10 + i));
            send(1'b1, tcode(i));
        end
        send(1'b1, 8'hBC);
        send(1'b0, 8'hBC);            // data byte equal to idle code, not K
        send(1'b1, 8'hFE);
        send(1'b1, 8'hBC);
        cmp("R9", "no error after clean traffic", {31'd0, proto_err_o}, 32'd0);
        // R9: data outside frame, then GR clears (R4)
        send(1'b0, 8'hA5);
        send(1'b1, 8'h3C);
        // R9: EOF outside frame
        send(1'b1, 8'hFE);
        send(1'b1, 8'h3C);
        // R9: second SOF restarts frame
        send(1'b1, 8'h1C); send(1'b0, 8'h01); send(1'b1, 8'h1C); send(1'b0, 8'h02);
        send(1'b1, 8'hFE);
        // R4: GR inside frame closes it; next data is an error
        send(1'b1, 8'h3C);
        send(1'b1, 8'h1C); send(1'b0, 8'h33); send(1'b1, 8'h3C); send(1'b0, 8'h44);
        // R9: unknown K
        send(1'b1, 8'h3C); send(1'b1, 8'h55); send(1'b1, 8'hBC);

        // constrained random traffic
        for (int n = 0; n < 20000; n++) send_rand();

        send(1'b1, 8'hBC);
        @(negedge clk);
        check_outputs();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule